// File: doc/BRIEF.md
# Compressed Instruction Mode Sequencer

This block follows the encoding mode of a fetched instruction stream that mixes standard 32-bit words with two compressed halfword forms. The two compressed forms are a short 10-bit form and a full 16-bit form. Each cycle the fetch side presents one 16-bit parcel. Bits are numbered 0 for the MSB through 15 for the LSB. The fetch side also raises a flag when a complete standard 32-bit word is being presented, in which case the parcel is that word's first halfword.

The sequencer does the following for each accepted parcel:
- It reports which form the parcel is.
- It reports the mode that applies to the next instruction.
- It raises flags for the illegal, nop, attn and reserved special encodings.

The mode is held in a register that starts in standard mode. A trap handler saves the mode from the exposed current-mode output and restores it later through a load port. The load port takes priority over the parcel stream. Opcode decoding beyond these mode and special-pattern fields is left to later stages.

Mode codes are 0 for standard, 1 for 16-bit compressed and 2 for "one standard word, then back to 16-bit". Form codes are 0 for standard 32-bit, 1 for 10-bit compressed, 2 for 16-bit compressed and 3 for 16-bit immediate format. The N bit is bit 0 (parcel[15]) and the M bit is bit 15 (parcel[0]). The major.minor field is bits 5-8 (parcel[10:7]).

Top module: `cms_seq`

## Requirements
- R1: After reset, cur_mode_o is 0 (standard) and accept_o is 0 while no parcel is valid.
- R2: In mode 0, a valid parcel whose bits 0-4 (parcel[15:11]) are all zero is accepted as form 1 whatever std_word_i is. A valid parcel with a nonzero parcel[15:11] and std_word_i=1 is accepted as form 0, and the mode stays 0. A valid parcel with a nonzero parcel[15:11] and std_word_i=0 is not accepted (accept_o=0), and the mode is unchanged.
- R3: For a form-1 parcel, M=0 gives next mode 0 and M=1 gives next mode 1.
- R4: In mode 1, with major.minor other than 4'b0011:
  - N,M=0,1 gives form 2 and next mode 1.
  - N,M=0,0 gives form 2 and next mode 0.
  - N,M=1,1 gives form 3 and next mode 1.
- R5: In mode 1, N,M=1,0 gives next mode 2. In mode 2, a valid parcel with std_word_i=1 is accepted as form 0 with next mode 1, whatever its bits are, and raises no special flag. In mode 2, a parcel with std_word_i=0 is not accepted, and the mode stays 2.
- R6: In mode 1, when major.minor is 4'b0011, N is ignored. The form is 2, never 3, and the next mode is 1 if M=1 and 0 if M=0.
- R7: The parcel 16'h0000 raises illegal_o, and 16'h0001 raises nop_o, both in form 1 and in form 2.
- R8: In mode 1 only, the following patterns with bits 5-15 all zero are special:
  - 16'h8000 is a nop.
  - 16'hC000 (bits 1-4 = 1000) is attn.
  - Any other nonzero bits 1-4 raise rsvd_o.
  
  The same patterns presented as a standard word in mode 0 raise no flag.
- R9: When mode_ld_i is 1, the next cycle's cur_mode_o equals mode_ld_val_i, overriding any parcel. A load value of 3 is taken as 0.
- R10: While parcel_vld_i is 0, accept_o and all four flags are 0, and the mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| parcel_i | input | 16 | Fetched halfword, parcel[15] is bit 0 |
| parcel_vld_i | input | 1 | Parcel is valid this cycle |
| std_word_i | input | 1 | A full standard 32-bit word is presented |
| mode_ld_i | input | 1 | Load the mode register (trap restore) |
| mode_ld_val_i | input | 2 | Mode value to load |
| cur_mode_o | output | 2 | Current mode, for saving |
| accept_o | output | 1 | Parcel consumed this cycle |
| form_o | output | 2 | Decoded form of the parcel (0 when not accepted) |
| next_mode_o | output | 2 | Mode for the next instruction |
| illegal_o | output | 1 | All-zero compressed parcel |
| nop_o | output | 1 | Compressed nop |
| attn_o | output | 1 | 16-bit attn |
| rsvd_o | output | 1 | Reserved 16-bit special pattern |

## Verification
The bench builds the block with its default parameters: a 16-bit parcel and a 5-bit primary opcode field. These values make every mode transition and special pattern reachable with literal parcels. Each table entry first loads a start mode through the trap-restore port and then applies one parcel. This reaches every mode and N,M combination, including the 001.1 subencoding and the one-shot return path, without long preamble sequences. Directed tests then cover reset, idle cycles, the invalid load value, and a load racing a mode-changing parcel.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int PARCEL_W = 16;
  localparam int PRIM_W   = 5;
  localparam int MAJ_W    = 4;

  localparam logic [1:0] MD_STD = 2'd0;
  localparam logic [1:0] MD_C16 = 2'd1;
  localparam logic [1:0] MD_ONE = 2'd2;

  localparam logic [1:0] FM_STD32 = 2'd0;
  localparam logic [1:0] FM_C10   = 2'd1;
  localparam logic [1:0] FM_C16   = 2'd2;
  localparam logic [1:0] FM_IMM   = 2'd3;

  localparam logic [MAJ_W-1:0] SUBENC_CODE = 4'b0011;
  localparam logic [3:0]       ATTN_MID    = 4'b1000;

  // Map an arbitrary 2-bit value to a legal mode code.
  function automatic logic [1:0] mode_sanitize(input logic [1:0] v);
    return (v == 2'd3) ? MD_STD : v;
  endfunction

  // Mode after a 10-bit compressed parcel.
  function automatic logic [1:0] next_after_c10(input logic m);
    return m ? MD_C16 : MD_STD;
  endfunction

  // Mode after a 16-bit compressed parcel.
  function automatic logic [1:0] next_after_c16(input logic n, input logic m,
                                                input logic subenc);
    logic n_eff;
    n_eff = n & ~subenc;
    case ({n_eff, m})
      2'b01:   return MD_C16;
      2'b00:   return MD_STD;
      2'b10:   return MD_ONE;
      default: return MD_C16;
    endcase
  endfunction

  // Form of a 16-bit compressed parcel.
  function automatic logic [1:0] form_of_c16(input logic n, input logic m,
                                             input logic subenc);
    return (n & m & ~subenc) ? FM_IMM : FM_C16;
  endfunction
endpackage

// File: rtl/cms_classify.sv
module cms_classify
  import cms_pkg::*;
#(
  parameter int PW  = PARCEL_W,
  parameter int PRW = PRIM_W,
  parameter int MJW = MAJ_W
) (
  input  logic [PW-1:0]  parcel,
  output logic           prim_zero,
  output logic           n_bit,
  output logic           m_bit,
  output logic           subenc,
  output logic           tail_zero,
  output logic           lone_m,
  output logic           parcel_zero,
  output logic [PRW-2:0] mid
);
  localparam int TOP     = PW - 1;
  localparam int MAJ_TOP = PW - 1 - PRW;

  logic [MJW-1:0] majmin;

  assign n_bit       = parcel[TOP];
  assign m_bit       = parcel[0];
  assign prim_zero   = (parcel[TOP -: PRW] == '0);
  assign majmin      = parcel[MAJ_TOP -: MJW];
  assign subenc      = (majmin == SUBENC_CODE);
  assign tail_zero   = (parcel[MAJ_TOP:0] == '0);
  assign lone_m      = (parcel[TOP:1] == '0) & m_bit;
  assign parcel_zero = (parcel == '0);
  assign mid         = parcel[TOP-1 -: PRW-1];
endmodule

// File: rtl/cms_special.sv
module cms_special
  import cms_pkg::*;
#(
  parameter int MW = PRIM_W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_c10,
  input  logic          is_c16,
  input  logic          parcel_zero,
  input  logic          lone_m,
  input  logic          n_bit,
  input  logic          tail_zero,
  input  logic [MW-1:0] mid,
  output logic          illegal,
  output logic          nop,
  output logic          attn,
  output logic          rsvd
);
  logic any_c;
  logic n_lone;

  assign any_c   = is_c10 | is_c16;
  assign n_lone  = is_c16 & n_bit & tail_zero;
  assign illegal = any_c & parcel_zero;
  assign nop     = (any_c & lone_m) | (n_lone & (mid == '0));
  assign attn    = n_lone & (mid == ATTN_MID);
  assign rsvd    = n_lone & (mid != '0) & (mid != ATTN_MID);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, nop, attn, rsvd}));                        // R7
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> parcel_zero);                                     // R7
  AST_ATTN_C16: assert property (@(posedge clk) disable iff (!rst_n)
    (attn || rsvd) |-> is_c16);                                   // R8
endmodule

// File: rtl/cms_mode_reg.sv
module cms_mode_reg
  import cms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [1:0] ld_val,
  input  logic       adv,
  input  logic [1:0] adv_mode,
  output logic [1:0] mode
);
  logic [1:0] mode_d;

  always_comb begin
    if (ld)       mode_d = mode_sanitize(ld_val);
    else if (adv) mode_d = adv_mode;
    else          mode_d = mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= MD_STD;
    else        mode <= mode_d;
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);                                                // R9
  AST_BAD_LOAD_STD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_val == 2'd3) |=> mode == MD_STD);                   // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv) |=> $stable(mode));                             // R10
endmodule

// File: rtl/cms_seq.sv
module cms_seq
  import cms_pkg::*;
#(
  parameter int PW  = PARCEL_W,
  parameter int PRW = PRIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] parcel_i,
  input  logic          parcel_vld_i,
  input  logic          std_word_i,
  input  logic          mode_ld_i,
  input  logic [1:0]    mode_ld_val_i,
  output logic [1:0]    cur_mode_o,
  output logic          accept_o,
  output logic [1:0]    form_o,
  output logic [1:0]    next_mode_o,
  output logic          illegal_o,
  output logic          nop_o,
  output logic          attn_o,
  output logic          rsvd_o
);
  localparam int MW = PRW - 1;

  logic          prim_zero, n_bit, m_bit, subenc, tail_zero, lone_m, parcel_zero;
  logic [MW-1:0] mid;
  logic [1:0]    cur;
  logic          in_std, in_c16, in_one;
  logic          is_c10, is_c16, std_acc, accept;
  logic [1:0]    nm_parcel;

  cms_classify #(.PW(PW), .PRW(PRW), .MJW(MAJ_W)) u_cls (
    .parcel(parcel_i), .prim_zero(prim_zero), .n_bit(n_bit), .m_bit(m_bit),
    .subenc(subenc), .tail_zero(tail_zero), .lone_m(lone_m),
    .parcel_zero(parcel_zero), .mid(mid)
  );

  assign in_std  = (cur == MD_STD);
  assign in_c16  = (cur == MD_C16);
  assign in_one  = (cur == MD_ONE);
  assign is_c10  = parcel_vld_i & in_std & prim_zero;
  assign is_c16  = parcel_vld_i & in_c16;
  assign std_acc = parcel_vld_i & std_word_i & ((in_std & ~prim_zero) | in_one);
  assign accept  = is_c10 | is_c16 | std_acc;

  always_comb begin
    if (is_c10) begin
      form_o    = FM_C10;
      nm_parcel = next_after_c10(m_bit);
    end else if (is_c16) begin
      form_o    = form_of_c16(n_bit, m_bit, subenc);
      nm_parcel = next_after_c16(n_bit, m_bit, subenc);
    end else if (std_acc) begin
      form_o    = FM_STD32;
      nm_parcel = in_one ? MD_C16 : MD_STD;
    end else begin
      form_o    = FM_STD32;
      nm_parcel = cur;
    end
  end

  cms_special #(.MW(MW)) u_spc (
    .clk(clk), .rst_n(rst_n), .is_c10(is_c10), .is_c16(is_c16),
    .parcel_zero(parcel_zero), .lone_m(lone_m), .n_bit(n_bit),
    .tail_zero(tail_zero), .mid(mid),
    .illegal(illegal_o), .nop(nop_o), .attn(attn_o), .rsvd(rsvd_o)
  );

  cms_mode_reg u_mreg (
    .clk(clk), .rst_n(rst_n), .ld(mode_ld_i), .ld_val(mode_ld_val_i),
    .adv(accept), .adv_mode(nm_parcel), .mode(cur)
  );

  assign cur_mode_o  = cur;
  assign accept_o    = accept;
  assign next_mode_o = nm_parcel;

  AST_C10_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode_o == MD_STD && parcel_vld_i && parcel_i[PW-1 -: PRW] == '0)
      |-> (accept_o && form_o == FM_C10));                        // R2
  AST_ONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode_o == MD_ONE && accept_o && !mode_ld_i) |=> cur_mode_o == MD_C16); // R5
  AST_SUBENC_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (is_c16 && subenc) |-> form_o != FM_IMM);                     // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !parcel_vld_i |-> !(accept_o || illegal_o || nop_o || attn_o || rsvd_o)); // R10
endmodule

// File: tb/cms_seq_tb.sv
`timescale 1ns/1ps
module cms_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] parcel = '0;
  logic        vld = 1'b0, sw = 1'b0, ld = 1'b0;
  logic [1:0]  ld_val = '0;
  logic [1:0]  cur_mode, form, next_mode;
  logic        accept, ill, nop, attn, rsvd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cms_seq u_dut (
    .clk(clk), .rst_n(rst_n), .parcel_i(parcel), .parcel_vld_i(vld),
    .std_word_i(sw), .mode_ld_i(ld), .mode_ld_val_i(ld_val),
    .cur_mode_o(cur_mode), .accept_o(accept), .form_o(form),
    .next_mode_o(next_mode), .illegal_o(ill), .nop_o(nop), .attn_o(attn),
    .rsvd_o(rsvd)
  );

  // Vector: [31:30] start mode, [29:14] parcel, [13] std word, [12:11] form,
  // [10:9] next mode, [8] accept, [7:4] {illegal,nop,attn,rsvd}, [3:0] req no.
  function automatic logic [31:0] mkv(input logic [1:0] lm, input logic [15:0] p,
                                      input logic s, input logic [1:0] f,
                                      input logic [1:0] n, input logic a,
                                      input logic [3:0] fl, input logic [3:0] r);
    return {lm, p, s, f, n, a, fl, r};
  endfunction

  localparam int NV = 24;
  localparam logic [31:0] VEC [NV] = '{
    mkv(2'd0, 16'h0400, 1'b0, 2'd1, 2'd0, 1'b1, 4'b0000, 4'd2),  // R2 / R3 C10, M=0
    mkv(2'd0, 16'h0401, 1'b0, 2'd1, 2'd1, 1'b1, 4'b0000, 4'd3),  // R3 C10, M=1
    mkv(2'd0, 16'h0400, 1'b1, 2'd1, 2'd0, 1'b1, 4'b0000, 4'd2),  // R2 std flag ignored
    mkv(2'd0, 16'h3800, 1'b1, 2'd0, 2'd0, 1'b1, 4'b0000, 4'd2),  // R2 standard word
    mkv(2'd0, 16'h3800, 1'b0, 2'd0, 2'd0, 1'b0, 4'b0000, 4'd2),  // R2 lone halfword
    mkv(2'd1, 16'h0201, 1'b0, 2'd2, 2'd1, 1'b1, 4'b0000, 4'd4),  // R4 N,M=01
    mkv(2'd1, 16'h0200, 1'b0, 2'd2, 2'd0, 1'b1, 4'b0000, 4'd4),  // R4 N,M=00
    mkv(2'd1, 16'h8201, 1'b0, 2'd3, 2'd1, 1'b1, 4'b0000, 4'd4),  // R4 N,M=11 imm
    mkv(2'd1, 16'h8200, 1'b0, 2'd2, 2'd2, 1'b1, 4'b0000, 4'd5),  // R5 N,M=10
    mkv(2'd2, 16'h1234, 1'b1, 2'd0, 2'd1, 1'b1, 4'b0000, 4'd5),  // R5 one-shot word
    mkv(2'd2, 16'h0000, 1'b1, 2'd0, 2'd1, 1'b1, 4'b0000, 4'd5),  // R5 zero word, no flag
    mkv(2'd2, 16'h1234, 1'b0, 2'd0, 2'd2, 1'b0, 4'b0000, 4'd5),  // R5 not a full word
    mkv(2'd1, 16'h8181, 1'b0, 2'd2, 2'd1, 1'b1, 4'b0000, 4'd6),  // R6 sub, M=1
    mkv(2'd1, 16'h8180, 1'b0, 2'd2, 2'd0, 1'b1, 4'b0000, 4'd6),  // R6 sub, M=0
    mkv(2'd1, 16'h0181, 1'b0, 2'd2, 2'd1, 1'b1, 4'b0000, 4'd6),  // R6 sub, N=0
    mkv(2'd0, 16'h0000, 1'b0, 2'd1, 2'd0, 1'b1, 4'b1000, 4'd7),  // R7 C10 illegal
    mkv(2'd0, 16'h0001, 1'b0, 2'd1, 2'd1, 1'b1, 4'b0100, 4'd7),  // R7 C10 nop
    mkv(2'd1, 16'h0000, 1'b0, 2'd2, 2'd0, 1'b1, 4'b1000, 4'd7),  // R7 C16 illegal
    mkv(2'd1, 16'h0001, 1'b0, 2'd2, 2'd1, 1'b1, 4'b0100, 4'd7),  // R7 C16 nop
    mkv(2'd1, 16'h8000, 1'b0, 2'd2, 2'd2, 1'b1, 4'b0100, 4'd8),  // R8 N nop
    mkv(2'd1, 16'hC000, 1'b0, 2'd2, 2'd2, 1'b1, 4'b0010, 4'd8),  // R8 attn
    mkv(2'd1, 16'h9000, 1'b0, 2'd2, 2'd2, 1'b1, 4'b0001, 4'd8),  // R8 reserved
    mkv(2'd1, 16'h8800, 1'b0, 2'd2, 2'd2, 1'b1, 4'b0001, 4'd8),  // R8 reserved low
    mkv(2'd0, 16'hC000, 1'b1, 2'd0, 2'd0, 1'b1, 4'b0000, 4'd8)   // R8 std: no flag
  };

  task automatic chk(input string tag, input int idx, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (item %0d): actual=%0h expected=%0h", tag, idx, act, exp);
    end
  endtask

  task automatic load_mode(input logic [1:0] m);
    @(negedge clk);
    ld = 1'b1; ld_val = m; vld = 1'b0;
    @(negedge clk);
    ld = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 mode in reset", 0, cur_mode, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after reset", 0, cur_mode, 2'd0);
    chk("R1 accept idle", 0, accept, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[3:0]);
      load_mode(v[31:30]);
      parcel = v[29:14]; sw = v[13]; vld = 1'b1;
      #1;
      chk({tag, " accept"}, i, accept, v[8]);
      if (v[8]) chk({tag, " form"}, i, form, v[12:11]);
      chk({tag, " next"}, i, next_mode, v[10:9]);
      chk({tag, " flags"}, i, {ill, nop, attn, rsvd}, v[7:4]);
      @(negedge clk);
      vld = 1'b0;
      chk({tag, " mode after"}, i, cur_mode, v[10:9]);
    end

    // R10: idle cycles ignore the parcel bus
    load_mode(2'd1);
    parcel = 16'h0000; vld = 1'b0; sw = 1'b1;
    #1;
    chk("R10 no accept", 0, accept, 1'b0);
    chk("R10 no flags", 0, {ill, nop, attn, rsvd}, 4'b0000);
    @(negedge clk);
    chk("R10 mode held", 0, cur_mode, 2'd1);

    // R9: invalid load value maps to standard
    load_mode(2'd3);
    chk("R9 load 3", 0, cur_mode, 2'd0);

    // R9: load overrides a mode-changing parcel
    load_mode(2'd1);
    @(negedge clk);
    parcel = 16'h0200; vld = 1'b1; sw = 1'b0; ld = 1'b1; ld_val = 2'd2;
    @(negedge clk);
    ld = 1'b0; vld = 1'b0;
    chk("R9 load wins", 0, cur_mode, 2'd2);

    // R5: one-shot chain, C10 enter, return path, back in 16-bit
    load_mode(2'd0);
    parcel = 16'h0401; vld = 1'b1; sw = 1'b0;
    @(negedge clk);
    parcel = 16'h8200;
    @(negedge clk);
    chk("R5 chain one-shot", 0, cur_mode, 2'd2);
    parcel = 16'h7C00; sw = 1'b1;
    @(negedge clk);
    vld = 1'b0; sw = 1'b0;
    chk("R5 chain back to 16-bit", 0, cur_mode, 2'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule